// File: doc/BRIEF.md
# Peripheral I/O with Interval Timer

This block is a small memory-mapped peripheral for an 8-bit processor bus. It provides two 8-bit ports, each paired with a direction register, and an interval timer with a selectable prescaler, one interrupt flag and an active-high interrupt request. Every bus access completes in one cycle. Read data is combinational from the offset. Read side effects, such as clearing the flag or loading the interrupt enable, take effect at the clock edge that ends the access. The port pins are modelled as internal registers. Only the bits marked as outputs by the direction register follow a data write.

The timer counts on a one-cycle `tick` enable, so the whole block stays in one clock domain. Writing a byte to a start offset loads an interval of that byte times the chosen divisor. When the interval runs out, the flag is raised and the timer runs on for 255 undivided ticks before it falls idle. Some offset bits choose the register and, on the same access, set the timer interrupt enable. A 2-bit edge-detect mode for port A bit 7 is kept and presented on an output pin. The block does not act on it.

Top module: `pio_interval_timer`

## Requirements
- R1: After reset, both port data registers read 0xFF, both direction registers read 0x00, and the flag byte reads 0x00. The timer reads 0, `irq` is low and `pa7_edge_mode` is 0.
- R2: When offset bit 2 is 0, offset bits 1:0 select the register: 0 is port A data, 1 is port A direction, 2 is port B data and 3 is port B direction. Each can be written and read back.
- R3: A port data write changes only the bits whose direction bit is 1. All other bits keep their previous value.
- R4: A write with offset bit 2 = 1 and bit 4 = 0 stores offset bits 1:0 on `pa7_edge_mode`. It leaves the ports, the timer, the flag and `irq` unchanged.
- R5: A write with offset bit 2 = 1 and bit 4 = 1 starts the timer with an interval of the written byte times a divisor. Offset bits 1:0 select the divisor: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 1024. Offset bit 3 becomes the timer interrupt enable.
- R6: A timer start drives `irq` low on the next cycle. It clears the flag unless the timer was in its counting phase.
- R7: When the interval expires, flag bit 7 sets and `irq` takes the value of the interrupt enable. The timer then counts 255 further undivided ticks and becomes idle.
- R8: A timer read returns 0 when idle. While counting, it returns the remaining ticks divided by the divisor, rounded down. In the post-count phase it returns the remaining raw ticks.
- R9: A timer read (offset bit 2 = 1, bit 0 = 0) also loads the interrupt enable from offset bit 3.
- R10: A flag read (offset bit 2 = 1, bit 0 = 1) returns the flag byte, with the timer flag in bit 7 and all other bits 0. It then clears the flag and `irq`.
- R11: The timer changes only on cycles where `tick` is high or a start write occurs.
- R12: The tick is applied before the access in the same cycle. An expiry that coincides with a start leaves the flag set, because the timer was counting, and the new interval is loaded. An expiry that coincides with a flag read returns the old flag byte and leaves the flag and `irq` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer count enable, one cycle per timer clock |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_off | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request, active high |
| pa7_edge_mode | output | 2 | Stored port A bit 7 edge-detect mode |

## Verification
The hardest situations to reach are an expiry that lands on the same cycle as a restart or a flag read. In normal use the flag is never set while the timer is counting. The only way to reach that state is an expiry and a start write on the same edge. The stimulus loads a short interval and consumes all but one tick. It then issues the start write or flag read with `tick` held high in the same cycle. Flag reads, `irq` and timer reads afterwards show which event took effect. Long post-count runs and truncated divided reads are reached by stepping exact tick counts from known intervals.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int OFF_W      = 5;
    localparam int MAX_SHIFT  = 10;
    localparam int POST_TICKS = 255;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_COUNT = 2'd1,
        TM_POST  = 2'd2
    } tm_state_e;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_PWR   = 3'd1,
        ACC_PRD   = 3'd2,
        ACC_EDGE  = 3'd3,
        ACC_START = 3'd4,
        ACC_TREAD = 3'd5,
        ACC_FREAD = 3'd6
    } acc_e;

    // log2 of the prescaler picked by the two low offset bits
    function automatic logic [3:0] div_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd0;
            2'd1:    return 4'd3;
            2'd2:    return 4'd6;
            default: return 4'd10;
        endcase
    endfunction

    function automatic acc_e decode(input logic en, input logic we,
                                    input logic [OFF_W-1:0] off);
        if (!en)          return ACC_NONE;
        if (!off[2])      return we ? ACC_PWR : ACC_PRD;
        if (we)           return off[4] ? ACC_START : ACC_EDGE;
        return off[0] ? ACC_FREAD : ACC_TREAD;
    endfunction

endpackage

// File: rtl/pit_ports.sv
module pit_ports #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int NPORT = 2;

    logic [DW-1:0] dat_q [NPORT];
    logic [DW-1:0] ddr_q [NPORT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++) begin
                dat_q[p] <= '1;
                ddr_q[p] <= '0;
            end
        end else if (wr_en) begin
            if (sel[0])
                ddr_q[sel[1]] <= wdata;
            else
                dat_q[sel[1]] <= (dat_q[sel[1]] & ~ddr_q[sel[1]]) |
                                 (wdata & ddr_q[sel[1]]);
        end
    end

    assign rdata = sel[0] ? ddr_q[sel[1]] : dat_q[sel[1]];

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R3: input-direction bits survive a data write
        p_ddr_mask_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel == {1'(p), 1'b0}) |=>
            (((dat_q[p] ^ $past(dat_q[p])) & ~$past(ddr_q[p])) == '0));
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = DW + MAX_SHIFT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] start_val,
    input  logic [1:0]    start_sel,
    output tm_state_e     state,
    output logic          expire,
    output logic [DW-1:0] rdval
);
    logic [CW-1:0] rem_q;
    logic [1:0]    sel_q;
    logic          last;

    assign last   = (rem_q <= CW'(1));
    assign expire = tick && (state == TM_COUNT) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TM_IDLE;
            rem_q <= '0;
            sel_q <= 2'd0;
        end else if (start) begin
            state <= TM_COUNT;
            rem_q <= CW'(start_val) << div_shift(start_sel);
            sel_q <= start_sel;
        end else if (tick) begin
            case (state)
                TM_COUNT: begin
                    if (last) begin
                        state <= TM_POST;
                        rem_q <= CW'(POST_TICKS);
                    end else begin
                        rem_q <= rem_q - CW'(1);
                    end
                end
                TM_POST: begin
                    if (last) begin
                        state <= TM_IDLE;
                        rem_q <= '0;
                    end else begin
                        rem_q <= rem_q - CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            TM_COUNT: rdval = DW'(rem_q >> div_shift(sel_q));
            TM_POST:  rdval = DW'(rem_q);
            default:  rdval = '0;
        endcase
    end

    // R7: post phase always holds a nonzero count no larger than its length
    p_post_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TM_POST) |-> (rem_q != '0 && rem_q <= CW'(POST_TICKS)));

    // R7: entering the post phase loads its full length
    p_enter_post_r7: assert property (@(posedge clk) disable iff (rst)
        (state == TM_POST && $past(state) == TM_COUNT) |-> (rem_q == CW'(POST_TICKS)));

    // R11: no tick, no start -> timer frozen
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> ($stable(rem_q) && $stable(state)));

endmodule

// File: rtl/pio_interval_timer.sv
module pio_interval_timer
    import pit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq,
    output logic [1:0]       pa7_edge_mode
);
    localparam int CW = DW + MAX_SHIFT;

    acc_e          kind;
    logic [DW-1:0] port_rdata;
    logic [DW-1:0] tm_rdata;
    tm_state_e     tm_state;
    logic          tm_expire;
    logic          flag_q;
    logic          irq_en_q;
    logic [DW-1:0] flag_byte;

    assign kind      = decode(bus_en, bus_we, bus_off);
    assign flag_byte = {flag_q, {(DW-1){1'b0}}};

    pit_ports #(.DW(DW)) u_ports (
        .clk   (clk),
        .rst   (rst),
        .wr_en (kind == ACC_PWR),
        .sel   (bus_off[1:0]),
        .wdata (bus_wdata),
        .rdata (port_rdata)
    );

    pit_timer #(.DW(DW), .CW(CW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (kind == ACC_START),
        .start_val (bus_wdata),
        .start_sel (bus_off[1:0]),
        .state     (tm_state),
        .expire    (tm_expire),
        .rdval     (tm_rdata)
    );

    // Tick first, then the access, judged against the pre-edge timer state
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q        <= 1'b0;
            irq           <= 1'b0;
            irq_en_q      <= 1'b0;
            pa7_edge_mode <= 2'd0;
        end else if (kind == ACC_START) begin
            irq_en_q <= bus_off[3];
            irq      <= 1'b0;
            flag_q   <= (tm_state == TM_COUNT) ? (flag_q | tm_expire) : 1'b0;
        end else begin
            if (kind == ACC_TREAD)
                irq_en_q <= bus_off[3];
            if (kind == ACC_EDGE)
                pa7_edge_mode <= bus_off[1:0];
            if (tm_expire) begin
                flag_q <= 1'b1;
                irq    <= irq_en_q;
            end else if (kind == ACC_FREAD) begin
                flag_q <= 1'b0;
                irq    <= 1'b0;
            end
        end
    end

    always_comb begin
        if (!bus_off[2])     bus_rdata = port_rdata;
        else if (bus_off[0]) bus_rdata = flag_byte;
        else                 bus_rdata = tm_rdata;
    end

    // R6: a start write always leaves irq low
    p_start_irq_low_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_off[2] && bus_off[4]) |=> !irq);

    // R10: a flag read with no coinciding expiry clears flag and irq
    p_fread_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_FREAD && !tm_expire) |=> (!irq && !flag_q));

    // R7: an interrupt is only ever requested with the flag raised
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    // R12: an expiry is never lost, even under a start or a flag read
    p_expire_sets_flag_r12: assert property (@(posedge clk) disable iff (rst)
        tm_expire |=> flag_q);

endmodule

// File: tb/pio_interval_timer_test.sv
module pio_interval_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_off = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [1:0] pa7_edge_mode;

    int vectors = 0;
    int errs = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 read data, 1 irq, 2 edge mode
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    pio_interval_timer uut (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_off       (bus_off),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq),
        .pa7_edge_mode (pa7_edge_mode)
    );

    // Monitor: drains the scoreboard one time unit after inputs settle
    initial forever begin
        @(negedge clk);
        #1;
        while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sbq.pop_front();
            case (it.kind)
                0:       got = bus_rdata;
                1:       got = {7'b0, irq};
                default: got = {6'b0, pa7_edge_mode};
            endcase
            vectors++;
            if (got !== it.exp) begin
                errs++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                         it.req, it.kind, got, it.exp);
            end
        end
    end

    task automatic drive(input logic en, input logic we, input logic [4:0] off,
                         input logic [7:0] d, input logic tk);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_off = off; bus_wdata = d; tick = tk;
    endtask

    task automatic wr(input logic [4:0] off, input logic [7:0] d);
        drive(1'b1, 1'b1, off, d, 1'b0);
    endtask

    task automatic rd(input logic [4:0] off, input logic [7:0] exp, input string req);
        drive(1'b1, 1'b0, off, 8'h00, 1'b0);
        sbq.push_back('{0, exp, req});
    endtask

    task automatic chk_irq(input logic exp, input string req);
        drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        sbq.push_back('{1, {7'b0, exp}, req});
    endtask

    task automatic chk_edge(input logic [1:0] exp, input string req);
        drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        sbq.push_back('{2, {6'b0, exp}, req});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, 8'hFF, "R1"); rd(5'h01, 8'h00, "R1");
        rd(5'h02, 8'hFF, "R1"); rd(5'h03, 8'h00, "R1");
        rd(5'h05, 8'h00, "R1"); rd(5'h04, 8'h00, "R1");
        chk_irq(1'b0, "R1"); chk_edge(2'd0, "R1");

        // R3: all inputs, data write ignored
        wr(5'h00, 8'h00); rd(5'h00, 8'hFF, "R3");
        // R2 / R3 map and masking
        wr(5'h01, 8'h0F); wr(5'h00, 8'h5A); rd(5'h00, 8'hFA, "R3");
        wr(5'h03, 8'hFF); wr(5'h02, 8'h3C); rd(5'h02, 8'h3C, "R2");
        rd(5'h03, 8'hFF, "R2"); rd(5'h01, 8'h0F, "R2");
        wr(5'h01, 8'hF0); wr(5'h00, 8'h00); rd(5'h00, 8'h0A, "R3");
        rd(5'h02, 8'h3C, "R2");

        // R4 edge mode stored only
        wr(5'h06, 8'hAA); chk_edge(2'd2, "R4"); chk_irq(1'b0, "R4");
        rd(5'h00, 8'h0A, "R4"); rd(5'h04, 8'h00, "R4"); rd(5'h05, 8'h00, "R4");
        wr(5'h07, 8'h00); chk_edge(2'd3, "R4");

        // R5 / R7 / R8 / R10: divisor 1, enabled
        wr(5'h1C, 8'd5); rd(5'h0C, 8'd5, "R5");
        ticks(4); rd(5'h0C, 8'd1, "R8"); chk_irq(1'b0, "R7");
        ticks(1); chk_irq(1'b1, "R7");
        rd(5'h0C, 8'd255, "R8");
        rd(5'h0D, 8'h80, "R10"); chk_irq(1'b0, "R10"); rd(5'h0D, 8'h00, "R10");
        ticks(254); rd(5'h0C, 8'd1, "R7");
        ticks(1); rd(5'h0C, 8'd0, "R7");

        // R5 / R8: divisor 8, disabled
        wr(5'h15, 8'd3); rd(5'h04, 8'd3, "R5");
        ticks(5); rd(5'h04, 8'd2, "R8");
        ticks(18); rd(5'h04, 8'd0, "R8");
        ticks(1); chk_irq(1'b0, "R7"); rd(5'h05, 8'h80, "R7");

        // R5: divisors 64 and 1024
        wr(5'h16, 8'd2); rd(5'h04, 8'd2, "R5");
        ticks(64); rd(5'h04, 8'd1, "R5");
        ticks(63); rd(5'h04, 8'd0, "R8");
        ticks(1); rd(5'h05, 8'h80, "R5");
        wr(5'h17, 8'd1); rd(5'h04, 8'd1, "R5");
        ticks(1); rd(5'h04, 8'd0, "R5");

        // R12: expiry coinciding with a restart
        wr(5'h1C, 8'd2); ticks(1);
        drive(1'b1, 1'b1, 5'h1C, 8'd4, 1'b1);
        chk_irq(1'b0, "R12"); rd(5'h0D, 8'h80, "R12"); rd(5'h0C, 8'd4, "R12");
        ticks(4); chk_irq(1'b1, "R7"); rd(5'h0D, 8'h80, "R10");

        // R6: start in post phase clears a set flag
        wr(5'h14, 8'd1); ticks(1); chk_irq(1'b0, "R7");
        wr(5'h1C, 8'd9); rd(5'h0D, 8'h00, "R6");

        // R12: expiry coinciding with a flag read
        wr(5'h1C, 8'd1);
        drive(1'b1, 1'b0, 5'h0D, 8'h00, 1'b1);
        sbq.push_back('{0, 8'h00, "R12"});
        chk_irq(1'b1, "R12"); rd(5'h0D, 8'h80, "R12"); chk_irq(1'b0, "R10");

        // R9: timer read sets and clears the enable
        wr(5'h14, 8'd3); rd(5'h0C, 8'd3, "R9");
        ticks(3); chk_irq(1'b1, "R9"); rd(5'h0D, 8'h80, "R9");
        wr(5'h1C, 8'd2); chk_irq(1'b0, "R6"); rd(5'h04, 8'd2, "R9");
        ticks(2); chk_irq(1'b0, "R9"); rd(5'h05, 8'h80, "R9");

        // R11: no ticks, no progress
        wr(5'h1C, 8'd2);
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        rd(5'h0C, 8'd2, "R11"); chk_irq(1'b0, "R11");

        drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        drive(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule